// File: doc/BRIEF.md
# Infrared Transmit Conditioner and Pin Selector

This block sits between a serial transmitter and the single output pin that drives an infrared LED. For serial traffic it can chop each low (active) bit with a 38 kHz carrier. The low part of each carrier period is programmable as a half, quarter, eighth or sixteenth of the period. The whole serial path can be inverted. Carrier chopping is suppressed while the supply is in brownout. A two-bit selector can instead give the pin to a general-purpose output, a real-energy pulse or a reactive-energy pulse. The pin value is registered, so changes to the selector or the duty code cannot glitch the LED.

On the receive side, the photodetector input can be inverted before it reaches the serial receiver. The receive pin can also be detached from the receiver and left for general I/O use. While it is detached, the receiver sees an idle-high line. A raw copy of the pin is always available to the general I/O logic.

Top module: `irtx_pinmux`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `tx_pin` is 1.
- R2: With `pin_sel`=0 and modulation inactive, `tx_pin` equals `uart_txd ^ tx_inv` one clock after the inputs are applied.
- R3: `pin_sel`=1 routes `gpio_out`, 2 routes `wpulse` and 3 routes `varpulse` to `tx_pin`, one clock later and never inverted.
- R4: Modulation is active when `mod_en`=1 and `brownout`=0. The carrier period is CLK_HZ/CARRIER_HZ clocks. Its phase is 0 on the first active cycle and advances by one each active cycle, modulo the period. The low part of the carrier comes first in each period.
- R5: `duty_sel` sets the number of low carrier cycles to period/2 for code 1, period/4 for code 2, period/8 for code 3 and period/16 for code 0.
- R6: With `pin_sel`=0 and `uart_txd`=0 under active modulation, the path is 0 during the low carrier cycles and 1 otherwise. With `uart_txd`=1 the path stays 1. The result is inverted when `tx_inv`=1.
- R7: `brownout`=1 forces modulation off even when `mod_en`=1, so the serial bit passes straight through.
- R8: `tx_inv` inverts the serial path both with and without modulation.
- R9: `uart_rxd` equals `rx_pin ^ rx_inv` when `rx_dis`=0 and is held at 1 when `rx_dis`=1. `gpio_rx` always equals `rx_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uart_txd | input | 1 | Serial transmit bit, idle high |
| gpio_out | input | 1 | General-purpose output value |
| wpulse | input | 1 | Real-energy pulse |
| varpulse | input | 1 | Reactive-energy pulse |
| brownout | input | 1 | Supply in brownout; suppresses modulation |
| mod_en | input | 1 | Carrier modulation enable |
| duty_sel | input | 2 | Carrier low-time code |
| tx_inv | input | 1 | Invert serial transmit path |
| pin_sel | input | 2 | Output pin source select |
| rx_pin | input | 1 | Photodetector input |
| rx_inv | input | 1 | Invert receive path |
| rx_dis | input | 1 | Detach receive pin from serial receiver |
| tx_pin | output | 1 | Registered LED drive |
| uart_rxd | output | 1 | Receive bit to serial receiver |
| gpio_rx | output | 1 | Raw receive pin to general I/O |

## Verification
The only hidden state is the carrier phase counter. A wrong phase, a wrong wrap point or a missed restart shows up on `tx_pin` as a low pulse that starts or ends in the wrong clock. This is visible within one carrier period of enabling modulation. The bench therefore compares `tx_pin` every clock against a phase model kept independently. It covers every duty code, restarts in the middle of a period, and brownout toggling. The selector and inversion paths have no memory, so any error appears on the clock right after the inputs change.

// File: rtl/irtx_pinmux.sv
module irtx_pinmux #(
  parameter int CLK_HZ     = 200_000_000,
  parameter int CARRIER_HZ = 38_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uart_txd,
  input  logic       gpio_out,
  input  logic       wpulse,
  input  logic       varpulse,
  input  logic       brownout,
  input  logic       mod_en,
  input  logic [1:0] duty_sel,
  input  logic       tx_inv,
  input  logic [1:0] pin_sel,
  input  logic       rx_pin,
  input  logic       rx_inv,
  input  logic       rx_dis,
  output logic       tx_pin,
  output logic       uart_rxd,
  output logic       gpio_rx
);
  localparam int PERIOD = CLK_HZ / CARRIER_HZ;
  localparam int CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] phase, low_len;
  logic mod_act, car_low, ser_path, pin_nxt;

  assign mod_act = mod_en & ~brownout;

  always_comb begin
    case (duty_sel)
      2'd1:    low_len = CW'(PERIOD / 2);
      2'd2:    low_len = CW'(PERIOD / 4);
      2'd3:    low_len = CW'(PERIOD / 8);
      default: low_len = CW'(PERIOD / 16);
    endcase
  end

  assign car_low  = phase < low_len;
  assign ser_path = (uart_txd | (mod_act & ~car_low)) ^ tx_inv;

  always_comb begin
    case (pin_sel)
      2'd0:    pin_nxt = ser_path;
      2'd1:    pin_nxt = gpio_out;
      2'd2:    pin_nxt = wpulse;
      default: pin_nxt = varpulse;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !mod_act)
      phase <= '0;
    else if (phase == CW'(PERIOD - 1))
      phase <= '0;
    else
      phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tx_pin <= 1'b1;
    else        tx_pin <= pin_nxt;
  end

  assign uart_rxd = rx_dis ? 1'b1 : (rx_pin ^ rx_inv);
  assign gpio_rx  = rx_pin;
endmodule

module irtx_pinmux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       uart_txd,
  input logic       gpio_out,
  input logic       wpulse,
  input logic       varpulse,
  input logic       brownout,
  input logic       tx_inv,
  input logic [1:0] pin_sel,
  input logic       rx_dis,
  input logic       tx_pin,
  input logic       uart_rxd
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> tx_pin);
  // R3
  sel_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_sel == 2'd1 |=> tx_pin == $past(gpio_out));
  // R3
  sel_wpulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_sel == 2'd2 |=> tx_pin == $past(wpulse));
  // R3
  sel_varpulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_sel == 2'd3 |=> tx_pin == $past(varpulse));
  // R6
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sel == 2'd0 && uart_txd && !tx_inv) |=> tx_pin);
  // R7
  brownout_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sel == 2'd0 && brownout) |=> tx_pin == $past(uart_txd ^ tx_inv));
  // R9
  rx_detach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dis |-> uart_rxd);
endmodule

bind irtx_pinmux irtx_pinmux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .uart_txd(uart_txd), .gpio_out(gpio_out),
  .wpulse(wpulse), .varpulse(varpulse), .brownout(brownout),
  .tx_inv(tx_inv), .pin_sel(pin_sel), .rx_dis(rx_dis),
  .tx_pin(tx_pin), .uart_rxd(uart_rxd)
);

// File: tb/irtx_pinmux_tb.sv
module irtx_pinmux_tb;
  localparam int CLK_HZ = 6_080_000;
  localparam int CAR_HZ = 38_000;
  localparam int P      = CLK_HZ / CAR_HZ;

  logic clk = 1'b0, rst_n = 1'b0;
  logic uart_txd = 1, gpio_out = 0, wpulse = 0, varpulse = 0, brownout = 0, mod_en = 0;
  logic [1:0] duty_sel = 0, pin_sel = 0;
  logic tx_inv = 0, rx_pin = 0, rx_inv = 0, rx_dis = 0;
  logic tx_pin, uart_rxd, gpio_rx;

  typedef struct {
    logic uart, gpio, wp, vp, bo, men, tinv;
    logic [1:0] duty, sel;
  } cfg_t;
  typedef struct { logic exp; string tag; } item_t;

  cfg_t  cfg = '{uart:1, gpio:0, wp:0, vp:0, bo:0, men:0, tinv:0, duty:0, sel:0};
  item_t q[$];
  string tag = "R1";
  int checks = 0, errors = 0, ph = 0;
  bit act_prev = 0, done = 0;

  always #2.5 clk = ~clk;

  irtx_pinmux #(.CLK_HZ(CLK_HZ), .CARRIER_HZ(CAR_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .uart_txd(uart_txd), .gpio_out(gpio_out),
    .wpulse(wpulse), .varpulse(varpulse), .brownout(brownout), .mod_en(mod_en),
    .duty_sel(duty_sel), .tx_inv(tx_inv), .pin_sel(pin_sel), .rx_pin(rx_pin),
    .rx_inv(rx_inv), .rx_dis(rx_dis), .tx_pin(tx_pin), .uart_rxd(uart_rxd),
    .gpio_rx(gpio_rx));

  function automatic int low_of(logic [1:0] d);
    case (d)
      2'd1: return P / 2;
      2'd2: return P / 4;
      2'd3: return P / 8;
      default: return P / 16;
    endcase
  endfunction

  task automatic check(logic act, logic exp, string t, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", t, what, act, exp);
    end
  endtask

  // driver: applies cfg each cycle and pushes the expected pin value
  task automatic drive(int n);
    for (int i = 0; i < n; i++) begin
      logic act, path, e;
      @(negedge clk);
      uart_txd = cfg.uart; gpio_out = cfg.gpio; wpulse = cfg.wp; varpulse = cfg.vp;
      brownout = cfg.bo; mod_en = cfg.men; tx_inv = cfg.tinv;
      duty_sel = cfg.duty; pin_sel = cfg.sel;
      act = cfg.men && !cfg.bo;
      if (!act || !act_prev) ph = 0;
      else ph = (ph + 1) % P;
      act_prev = act;
      if (cfg.uart) path = 1'b1;
      else if (act) path = (ph >= low_of(cfg.duty));
      else path = 1'b0;
      case (cfg.sel)
        2'd0: e = path ^ cfg.tinv;
        2'd1: e = cfg.gpio;
        2'd2: e = cfg.wp;
        default: e = cfg.vp;
      endcase
      q.push_back('{exp: e, tag: tag});
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(tx_pin, it.exp, it.tag, "tx_pin");
      end
    end
  end

  task automatic rx_case(logic p, logic inv, logic dis);
    @(negedge clk);
    rx_pin = p; rx_inv = inv; rx_dis = dis;
    #1;
    check(uart_rxd, dis ? 1'b1 : (p ^ inv), "R9", "uart_rxd");
    check(gpio_rx, p, "R9", "gpio_rx");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tx_pin, 1'b1, "R1", "tx_pin in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(tx_pin, 1'b1, "R1", "tx_pin after reset");

    // R2 pass-through, no modulation
    tag = "R2";
    for (int i = 0; i < 12; i++) begin cfg.uart = (i % 3) != 0; drive(2); end
    // R8 inversion without modulation
    tag = "R8"; cfg.tinv = 1;
    for (int i = 0; i < 8; i++) begin cfg.uart = i[0]; drive(3); end
    cfg.tinv = 0;

    // R3 alternate sources
    tag = "R3";
    for (int s = 1; s < 4; s++) begin
      cfg.sel = 2'(s);
      for (int i = 0; i < 8; i++) begin
        cfg.gpio = i[0]; cfg.wp = i[1]; cfg.vp = i[0] ^ i[2];
        cfg.tinv = i[2]; cfg.uart = i[1];
        drive(2);
      end
    end
    cfg.sel = 0; cfg.tinv = 0; cfg.uart = 1;

    // R4/R5 every duty code, two periods each
    cfg.men = 1; cfg.uart = 0;
    for (int d = 0; d < 4; d++) begin
      tag = (d == 1) ? "R4" : "R5";
      cfg.duty = 2'(d);
      drive(2 * P + 7);
    end
    // R4 restart at phase zero after a mid-period disable
    tag = "R4"; cfg.duty = 2'd1;
    cfg.men = 0; drive(3);
    cfg.men = 1; drive(P / 3);
    cfg.men = 0; drive(1);
    cfg.men = 1; drive(P + 5);

    // R6 idle-high while modulating
    tag = "R6"; cfg.uart = 1; drive(P);
    cfg.uart = 0; cfg.duty = 2'd2; drive(P / 2);
    cfg.uart = 1; drive(9);
    cfg.uart = 0; drive(P);

    // R7 brownout overrides the enable
    tag = "R7"; cfg.bo = 1;
    for (int i = 0; i < 6; i++) begin cfg.uart = i[0]; drive(P / 4); end
    cfg.uart = 0; cfg.bo = 0; drive(P / 2 + 3);
    cfg.bo = 1; drive(5);
    cfg.bo = 0; drive(P);

    // R8 inversion with modulation
    tag = "R8"; cfg.tinv = 1; cfg.duty = 2'd3; drive(2 * P);
    cfg.uart = 1; drive(10);
    cfg.men = 0; cfg.tinv = 0; drive(4);

    // R9 receive path
    for (int k = 0; k < 8; k++) rx_case(k[0], k[1], k[2]);

    drive(2);
    @(posedge clk); #2;
    finish_run();
  end
endmodule